// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Master

This block runs a three-wire serial EEPROM that holds 64 sixteen-bit words. The chip-select, serial-clock and data-in pins are registered outputs, and data-out is an input. A client raises a one-cycle request with a 6-bit word address, a read/write flag and, for writes, a 16-bit data word. The master then produces every pin transition on its own. A read sets up the bus, shifts out the read command and the address, shifts in the word and returns the bus to standby.

A write does more. It opens write access with an enable command and restarts the device with a standby sequence. It then shifts out the write command, the address and the data. A second standby starts the internal program cycle, and the master polls data-out until the device reports ready. Last, it closes write access with a disable command and runs a cleanup that deselects the device.

Each pin state is held for a fixed settle interval, counted in system clocks. The master signals the end of every operation with a one-cycle done pulse. Read data is valid with that pulse, and a write whose ready poll ran out pulses a timeout flag in the same cycle.

Top module: `uwire_eeprom_master`

## Requirements
- R1: While and directly after reset, chip select, serial clock and data-in are low, and busy, done and timeout_err are low.
- R2: Every operation starts with a setup step: clock and data-in low with chip select unchanged, then chip select raised. A read then shifts out 9 command bits, most significant first: opcode 3'b110 followed by the 6-bit address. Each bit is a data-in step, a clock-high step and a clock-low step, and data-in never changes while the clock is high.
- R3: After its command, a read shifts in 16 bits, most significant first. Each bit is a clock-high step followed by a clock-low step. Data-out is taken near the end of the clock-high step, data-in stays low, and the word appears on rd_data with the done pulse.
- R4: Every shift-out group ends with one extra step in which data-in returns low while chip select is high and clock is low.
- R5: A standby is four steps with (chip select, clock) = (0,0), (0,1), (1,1), (1,0) and data-in low. A read ends with one standby.
- R6: A write opens with setup and the 9-bit enable command 5'b10011 followed by four zero bits. After the closing data-in step and a standby, it shifts out 25 bits: opcode 3'b101, the 6-bit address and the 16 data bits.
- R7: After the write bits and a standby, the master holds chip select high and clock low. It samples data-out once per settle interval, for at most POLL_LIMIT samples, and moves on right after the first high sample.
- R8: If all POLL_LIMIT samples are low, the write still finishes its tail sequence, and timeout_err pulses in the same cycle as done. A high sample on the last allowed poll gives no timeout.
- R9: After polling, the write does a standby, then shifts out the 9-bit disable command 5'b10000 followed by four zero bits, then the closing data-in step. It ends with cleanup: chip select and data-in low, then one clock high step and one clock low step.
- R10: A request is accepted only while busy is low, and a request while busy has no effect on pins or results. Done and timeout_err last one cycle, and pins do not change while idle.
- R11: Every pin state is held for exactly SETTLE_CYCLES clocks before the next step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| timeout_err | output | 1 | One-cycle pulse with done when the ready poll ran out |
| rd_data | output | DATA_W | Read word, valid with done after a read |
| mw_cs | output | 1 | Device chip select |
| mw_sk | output | 1 | Device serial clock |
| mw_di | output | 1 | Serial data into the device |
| mw_do | input | 1 | Serial data from the device |

## Verification
The bench compares the pins against a reference timeline on every clock, so it targets the points where the sequence can slip:
- **Bit order and step count.** An address of all ones, an address of zero and mixed words with an MSB-first mix-up would send a reversed or shifted command or word.
- **Poll boundaries.** The bench raises ready on the first sample, on a middle sample and on exactly the last allowed sample. It also never raises ready. A poll counter that is off by one would flag a false timeout, or miss a real one by a single settle interval.
- **Write tail and stray requests.** A design that skipped the tail after a timeout would leave write access enabled. A master that sampled requests while busy would restart mid-sequence, and the bench sends such stray requests during a read.

// File: rtl/uwm_pkg.sv
package uwm_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_SHOUT,
        PH_DILOW,
        PH_SHIN,
        PH_STBY,
        PH_POLL,
        PH_CLEAN
    } phase_e;

    localparam int SEG_W = 4;

    // Command opcodes (leading bits sent first)
    localparam logic [2:0] OPC_READ   = 3'b110;
    localparam logic [2:0] OPC_WRITE  = 3'b101;
    localparam logic [2:0] OPC_MODE   = 3'b100;
    localparam logic [1:0] MODE_WR_ON  = 2'b11;
    localparam logic [1:0] MODE_WR_OFF = 2'b00;

    // Segment program: which phase runs at each position of an operation
    function automatic phase_e seg_phase(input logic wr, input logic [SEG_W-1:0] seg);
        phase_e ph;
        ph = PH_IDLE;
        if (!wr) begin
            case (seg)
                4'd0:    ph = PH_SETUP;
                4'd1:    ph = PH_SHOUT;
                4'd2:    ph = PH_DILOW;
                4'd3:    ph = PH_SHIN;
                4'd4:    ph = PH_STBY;
                default: ph = PH_IDLE;
            endcase
        end else begin
            case (seg)
                4'd0:    ph = PH_SETUP;
                4'd1:    ph = PH_SHOUT;   // write enable
                4'd2:    ph = PH_DILOW;
                4'd3:    ph = PH_STBY;
                4'd4:    ph = PH_SHOUT;   // write opcode, address, data
                4'd5:    ph = PH_DILOW;
                4'd6:    ph = PH_STBY;
                4'd7:    ph = PH_POLL;
                4'd8:    ph = PH_STBY;
                4'd9:    ph = PH_SHOUT;   // write disable
                4'd10:   ph = PH_DILOW;
                4'd11:   ph = PH_CLEAN;
                default: ph = PH_IDLE;
            endcase
        end
        return ph;
    endfunction

endpackage

// File: rtl/uwm_sync.sv
module uwm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/uwm_settle_timer.sv
module uwm_settle_timer #(
    parameter int SETTLE_CYCLES = 2500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic expire
);
    localparam int CW = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
    localparam logic [CW-1:0] LOAD = CW'(SETTLE_CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)          cnt_d = LOAD;
        else if (run)       cnt_d = (cnt_q == '0) ? LOAD : cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire = run && !start && (cnt_q == '0);

    // Sampling of the synchronised data-out needs a few cycles per step
    initial assert (SETTLE_CYCLES >= 3);

    p_cnt_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LOAD);
endmodule

// File: rtl/uwm_frame_gen.sv
module uwm_frame_gen
    import uwm_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16,
    localparam int SW = 3 + ADDR_W + DATA_W,
    localparam int LW = $clog2(SW + 1)
) (
    input  logic              wr,
    input  logic [SEG_W-1:0]  seg,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [SW-1:0]     word,
    output logic [LW-1:0]     len
);
    localparam int CMD_LEN = 3 + ADDR_W;
    localparam int PAD_W   = ADDR_W - 2;

    always_comb begin
        word = '0;
        len  = LW'(CMD_LEN);
        if (!wr) begin
            word = {OPC_READ, addr, {DATA_W{1'b0}}};
        end else begin
            case (seg)
                4'd1: word = {OPC_MODE, MODE_WR_ON, {PAD_W{1'b0}}, {DATA_W{1'b0}}};
                4'd4: begin
                    word = {OPC_WRITE, addr, wdata};
                    len  = LW'(SW);
                end
                4'd9: word = {OPC_MODE, MODE_WR_OFF, {PAD_W{1'b0}}, {DATA_W{1'b0}}};
                default: word = '0;
            endcase
        end
    end
endmodule

// File: rtl/uwm_sequencer.sv
module uwm_sequencer
    import uwm_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16,
    parameter int POLL_LIMIT = 200,
    localparam int SW = 3 + ADDR_W + DATA_W,
    localparam int LW = $clog2(SW + 1),
    localparam int PW = $clog2(POLL_LIMIT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              do_sync,
    input  logic              expire,
    input  logic [SW-1:0]     fg_word,
    input  logic [LW-1:0]     fg_len,
    output logic              fg_wr,
    output logic [SEG_W-1:0]  fg_seg,
    output logic [ADDR_W-1:0] fg_addr,
    output logic [DATA_W-1:0] fg_wdata,
    output logic              tmr_start,
    output logic              tmr_run,
    output logic              busy,
    output logic              done,
    output logic              timeout_err,
    output logic [DATA_W-1:0] rd_data,
    output logic              mw_cs,
    output logic              mw_sk,
    output logic              mw_di
);
    typedef struct packed {
        phase_e            ph;
        logic              wr;
        logic [SEG_W-1:0]  seg;
        logic [1:0]        sub;
        logic [LW-1:0]     bits_left;
        logic [SW-1:0]     sreg;
        logic [DATA_W-1:0] shin;
        logic [PW-1:0]     polls;
        logic              tmo;
        logic              cs;
        logic              sk;
        logic              di;
        logic              done;
        logic              err;
        logic [DATA_W-1:0] rdata;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } state_t;

    state_t q, d;
    logic   finish;
    phase_e nph;
    logic [SEG_W-1:0] nseg;

    assign nseg     = q.seg + 1'b1;
    assign fg_wr    = q.wr;
    assign fg_seg   = nseg;
    assign fg_addr  = q.addr;
    assign fg_wdata = q.wdata;
    assign nph      = seg_phase(q.wr, nseg);

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        d.err     = 1'b0;
        finish    = 1'b0;
        tmr_start = 1'b0;

        if (q.ph == PH_IDLE) begin
            if (req_valid) begin
                d.ph    = PH_SETUP;
                d.wr    = req_write;
                d.addr  = req_addr;
                d.wdata = req_wdata;
                d.seg   = '0;
                d.sub   = '0;
                d.tmo   = 1'b0;
                d.polls = '0;
                d.sk    = 1'b0;
                d.di    = 1'b0;
                tmr_start = 1'b1;
            end
        end else if (expire) begin
            case (q.ph)
                PH_SETUP: begin
                    if (q.sub == 2'd0) begin
                        d.sub = 2'd1;
                        d.cs  = 1'b1;
                    end else begin
                        finish = 1'b1;
                    end
                end
                PH_SHOUT: begin
                    case (q.sub)
                        2'd0: begin d.sub = 2'd1; d.sk = 1'b1; end
                        2'd1: begin d.sub = 2'd2; d.sk = 1'b0; end
                        default: begin
                            if (q.bits_left == LW'(1)) begin
                                finish = 1'b1;
                            end else begin
                                d.sreg      = q.sreg << 1;
                                d.bits_left = q.bits_left - 1'b1;
                                d.di        = q.sreg[SW-2];
                                d.sub       = 2'd0;
                            end
                        end
                    endcase
                end
                PH_DILOW: finish = 1'b1;
                PH_SHIN: begin
                    if (q.sub == 2'd0) begin
                        d.shin = {q.shin[DATA_W-2:0], do_sync};
                        d.sub  = 2'd1;
                        d.sk   = 1'b0;
                    end else if (q.bits_left == LW'(1)) begin
                        finish = 1'b1;
                    end else begin
                        d.bits_left = q.bits_left - 1'b1;
                        d.sub       = 2'd0;
                        d.sk        = 1'b1;
                    end
                end
                PH_STBY: begin
                    case (q.sub)
                        2'd0: begin d.sub = 2'd1; d.sk = 1'b1; end
                        2'd1: begin d.sub = 2'd2; d.cs = 1'b1; end
                        2'd2: begin d.sub = 2'd3; d.sk = 1'b0; end
                        default: finish = 1'b1;
                    endcase
                end
                PH_POLL: begin
                    if (do_sync) begin
                        finish = 1'b1;
                    end else if (q.polls == PW'(POLL_LIMIT - 1)) begin
                        d.tmo  = 1'b1;
                        finish = 1'b1;
                    end else begin
                        d.polls = q.polls + 1'b1;
                    end
                end
                PH_CLEAN: begin
                    case (q.sub)
                        2'd0: begin d.sub = 2'd1; d.sk = 1'b1; end
                        2'd1: begin d.sub = 2'd2; d.sk = 1'b0; end
                        default: finish = 1'b1;
                    endcase
                end
                default: d.ph = PH_IDLE;
            endcase

            if (finish) begin
                d.seg = nseg;
                d.sub = '0;
                d.ph  = nph;
                case (nph)
                    PH_IDLE: begin
                        d.done  = 1'b1;
                        d.err   = d.tmo;
                        d.rdata = d.shin;
                    end
                    PH_SHOUT: begin
                        d.sreg      = fg_word;
                        d.bits_left = fg_len;
                        d.di        = fg_word[SW-1];
                        d.sk        = 1'b0;
                    end
                    PH_DILOW: d.di = 1'b0;
                    PH_SHIN: begin
                        d.bits_left = LW'(DATA_W);
                        d.sk        = 1'b1;
                        d.di        = 1'b0;
                    end
                    PH_STBY: begin
                        d.cs = 1'b0;
                        d.sk = 1'b0;
                    end
                    PH_POLL:  d.polls = '0;
                    PH_CLEAN: begin
                        d.cs = 1'b0;
                        d.di = 1'b0;
                    end
                    default: d.ph = nph;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tmr_run     = (q.ph != PH_IDLE);
    assign busy        = (q.ph != PH_IDLE);
    assign done        = q.done;
    assign timeout_err = q.err;
    assign rd_data     = q.rdata;
    assign mw_cs       = q.cs;
    assign mw_sk       = q.sk;
    assign mw_di       = q.di;

    // R11: pins move only when the settle timer expires
    p_pin_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph != PH_IDLE && !expire) |=> $stable({q.cs, q.sk, q.di}));

    // R2: data-in never changes while the clock is high
    p_di_steady_sk_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.di) |-> !q.sk);

    // R3: data-in held low while shifting in
    p_shin_di_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_SHIN) |-> !q.di);

    // R7: poll count never passes its limit
    p_poll_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_POLL) |-> (q.polls < PW'(POLL_LIMIT)));

    // R8: timeout flag only together with done
    p_err_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        q.err |-> q.done);

    // R10: done is a single-cycle pulse
    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);

    // R10: pins quiet while idle without a request
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_IDLE && !req_valid) |=> $stable({q.cs, q.sk, q.di}));
endmodule

// File: rtl/uwire_eeprom_master.sv
module uwire_eeprom_master
    import uwm_pkg::*;
#(
    parameter int ADDR_W        = 6,
    parameter int DATA_W        = 16,
    parameter int SETTLE_CYCLES = 2500,
    parameter int POLL_LIMIT    = 200,
    parameter int SYNC_STAGES   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic              timeout_err,
    output logic [DATA_W-1:0] rd_data,
    output logic              mw_cs,
    output logic              mw_sk,
    output logic              mw_di,
    input  logic              mw_do
);
    localparam int SW = 3 + ADDR_W + DATA_W;
    localparam int LW = $clog2(SW + 1);

    logic              do_sync;
    logic              expire, tmr_start, tmr_run;
    logic              fg_wr;
    logic [SEG_W-1:0]  fg_seg;
    logic [ADDR_W-1:0] fg_addr;
    logic [DATA_W-1:0] fg_wdata;
    logic [SW-1:0]     fg_word;
    logic [LW-1:0]     fg_len;

    uwm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (mw_do),
        .sync_out (do_sync)
    );

    uwm_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (tmr_start),
        .run    (tmr_run),
        .expire (expire)
    );

    uwm_frame_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
        .wr    (fg_wr),
        .seg   (fg_seg),
        .addr  (fg_addr),
        .wdata (fg_wdata),
        .word  (fg_word),
        .len   (fg_len)
    );

    uwm_sequencer #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .POLL_LIMIT (POLL_LIMIT)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .do_sync     (do_sync),
        .expire      (expire),
        .fg_word     (fg_word),
        .fg_len      (fg_len),
        .fg_wr       (fg_wr),
        .fg_seg      (fg_seg),
        .fg_addr     (fg_addr),
        .fg_wdata    (fg_wdata),
        .tmr_start   (tmr_start),
        .tmr_run     (tmr_run),
        .busy        (busy),
        .done        (done),
        .timeout_err (timeout_err),
        .rd_data     (rd_data),
        .mw_cs       (mw_cs),
        .mw_sk       (mw_sk),
        .mw_di       (mw_di)
    );
endmodule

// File: tb/test_uwire_eeprom_master.sv
module test_uwire_eeprom_master;
    localparam int T     = 3;
    localparam int LIMIT = 200;

    typedef struct packed {
        logic cs, sk, di, dout, busy, done, err, chk_rd;
        logic [15:0] rd;
    } ent_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [5:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        mw_do = 1'b0;
    logic        busy, done, timeout_err, mw_cs, mw_sk, mw_di;
    logic [15:0] rd_data;

    int    checks = 0, fails = 0;
    ent_t  exp_q[$];
    string tag_q[$];
    logic  last_cs = 1'b0;
    string idle_tag = "R1";

    always #10 clk = ~clk;

    uwire_eeprom_master #(.SETTLE_CYCLES(T), .POLL_LIMIT(LIMIT)) i_uwire_eeprom_master (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .timeout_err(timeout_err), .rd_data(rd_data), .mw_cs(mw_cs),
        .mw_sk(mw_sk), .mw_di(mw_di), .mw_do(mw_do)
    );

    function automatic void step(logic cs, logic sk, logic di, logic dout, string tag);
        for (int k = 0; k < T; k++) begin
            exp_q.push_back('{cs:cs, sk:sk, di:di, dout:dout, busy:1'b1,
                              done:1'b0, err:1'b0, chk_rd:1'b0, rd:16'h0});
            tag_q.push_back(tag);
        end
    endfunction

    function automatic void shout(logic [24:0] w, int n, string tag);
        for (int i = n - 1; i >= 0; i--) begin
            step(1, 0, w[i], 0, tag);
            step(1, 1, w[i], 0, tag);
            step(1, 0, w[i], 0, tag);
        end
        step(1, 0, 0, 0, "R4");
    endfunction

    function automatic void standby(string tag);
        step(0, 0, 0, 0, tag);
        step(0, 1, 0, 0, tag);
        step(1, 1, 0, 0, tag);
        step(1, 0, 0, 0, tag);
    endfunction

    function automatic void finish_entry(logic cs, logic err, logic chk, logic [15:0] rd, string tag);
        exp_q.push_back('{cs:cs, sk:1'b0, di:1'b0, dout:1'b0, busy:1'b0,
                          done:1'b1, err:err, chk_rd:chk, rd:rd});
        tag_q.push_back(tag);
    endfunction

    function automatic void build_read(logic [5:0] a, logic [15:0] dat);
        step(last_cs, 0, 0, 0, "R2");
        step(1, 0, 0, 0, "R2");
        shout({16'h0, 3'b110, a}, 9, "R2");
        for (int i = 15; i >= 0; i--) begin
            step(1, 1, 0, dat[i], "R3");
            step(1, 0, 0, dat[i], "R3");
        end
        standby("R5");
        finish_entry(1, 0, 1, dat, "R3");
        last_cs = 1'b1;
    endfunction

    function automatic void build_write(logic [5:0] a, logic [15:0] dat, int p);
        int nlow;
        step(last_cs, 0, 0, 0, "R6");
        step(1, 0, 0, 0, "R6");
        shout({16'h0, 9'b10011_0000}, 9, "R6");
        standby("R5");
        shout({3'b101, a, dat}, 25, "R6");
        standby("R7");
        nlow = (p < LIMIT) ? p : LIMIT;
        for (int i = 0; i < nlow; i++) step(1, 0, 0, 0, "R7");
        if (p < LIMIT) step(1, 0, 0, 1, "R7");
        standby("R9");
        shout({16'h0, 9'b10000_0000}, 9, "R9");
        step(0, 0, 0, 0, "R9");
        step(0, 1, 0, 0, "R9");
        step(0, 0, 0, 0, "R9");
        finish_entry(0, (p >= LIMIT), 0, 16'h0, "R8");
        last_cs = 1'b0;
    endfunction

    task automatic tick();
        ent_t  e;
        string tg;
        logic [5:0] got, expv;
        @(negedge clk);
        if (exp_q.size() > 0) begin
            e  = exp_q.pop_front();
            tg = tag_q.pop_front();
        end else begin
            e  = '{cs:last_cs, sk:1'b0, di:1'b0, dout:1'b0, busy:1'b0,
                   done:1'b0, err:1'b0, chk_rd:1'b0, rd:16'h0};
            tg = idle_tag;
        end
        mw_do = e.dout;
        got  = {mw_cs, mw_sk, mw_di, busy, done, timeout_err};
        expv = {e.cs, e.sk, e.di, e.busy, e.done, e.err};
        checks++;
        if (got !== expv || (e.chk_rd && rd_data !== e.rd)) begin
            fails++;
            $display("FAIL %s t=%0t: cs/sk/di/busy/done/err got %b expected %b, rd_data got %h expected %h",
                     tg, $time, got, expv, rd_data, e.rd);
        end
    endtask

    task automatic run_req(logic wr, logic [5:0] a, logic [15:0] dat, int p, bit stray);
        tick();
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = dat;
        if (wr) build_write(a, dat, p);
        else    build_read(a, dat);
        tick();
        req_valid = 1'b0;
        while (exp_q.size() > 0) begin
            tick();
            // R10: stray requests during busy must change nothing
            if (stray && exp_q.size() > 20 && exp_q.size() < 120) begin
                req_valid = 1'b1; req_write = ~wr; req_addr = ~a; req_wdata = ~dat;
            end else begin
                req_valid = 1'b0;
            end
        end
        req_valid = 1'b0;
        repeat (4) tick();
    endtask

    initial begin
        repeat (4) tick();            // R1 reset state
        rst_n = 1'b1;
        repeat (3) tick();            // R1 just after reset
        idle_tag = "R10";
        run_req(0, 6'h2A, 16'hC3A5, 0, 0);      // R2 R3 R4 R5
        run_req(0, 6'h3F, 16'hFFFF, 0, 0);
        run_req(0, 6'h00, 16'h0001, 0, 0);
        run_req(1, 6'h05, 16'h1234, 0, 0);      // R6 R7 R9, ready at first poll
        run_req(1, 6'h3F, 16'h8001, 7, 0);      // R7 middle poll
        run_req(1, 6'h11, 16'hA5A5, LIMIT-1, 0);// R8 boundary, no timeout
        run_req(1, 6'h22, 16'h5A5A, LIMIT, 0);  // R8 timeout
        run_req(0, 6'h15, 16'h6B2D, 0, 1);      // R10 stray requests
        run_req(0, 6'h01, 16'h8000, 0, 0);      // R11 timing after all above
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not end, got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule